// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a single-clock static RAM that works at the cycle level. It holds words made of four 9-bit byte lanes. The address, the write data and every control input are captured on the rising clock edge. Reads are flow-through: once a cycle has been captured, the stored word is presented on `dout` during the following clock period, with no extra output register.

A burst begins on one of two address strobes, `strb_proc_n` or `strb_ctl_n`. The strobe loads the external address, and an internal 2-bit beat counter then supplies the two low address bits. That counter moves forward only on cycles where `adv_n` is low. The order of the beats is fixed when the burst is loaded. It is a linear count when `ilv_mode` is low and an XOR pattern when it is high. A write covers either any subset of the lanes, chosen by byte-write enable and the per-lane selects, or all lanes under global write. A cycle can only start when all three chip selects are active. The `sleep` input freezes the block and keeps the stored data.

The bidirectional data pin is split into `din` for input and `dout` for output, with `dout_en` telling when the output would be driven.

Top module: `sync_burst_sram`

## Requirements
- R1: Suppose the captured cycle is an active read, `oe_n` is low and `sleep` is low. Then during the following clock period `dout` equals the stored word at the current burst address and `dout_en` is 1.
- R2: A strobe taken while all chip selects are active (`cs0_n`=0, `cs1`=1, `cs2_n`=0) loads `addr` as the burst base, and beat 0 addresses exactly `addr`.
- R3: On a continuation cycle (no strobe taken), `adv_n`=0 moves the beat counter forward by one. With `adv_n`=1 the same address is used again.
- R4: When `ilv_mode` is 0 at load, the two low address bits of beat n are (a+n) mod 4, where a is the two low bits of the loaded address. For a=3 the order is 3,0,1,2.
- R5: When `ilv_mode` is 1 at load, the two low address bits of beat n are a XOR n. For a=2 the order is 2,3,0,1.
- R6: When `gwr_n`=1 and `bwr_n`=0, lane i (bits 9i+8 down to 9i of `din`) is written only if `lane_sel_n[i]`=0. All other lanes keep their old contents.
- R7: When `gwr_n`=0, all four lanes are written whatever `bwr_n` and `lane_sel_n` are.
- R8: A cycle started by `strb_proc_n` is always a read, even while write controls are active. If both strobes are low, the processor strobe takes effect.
- R9: `strb_proc_n` is ignored while the chip is deselected. `strb_ctl_n` taken while deselected ends any burst: reads stop, and advances and writes are ignored until the next load.
- R10: While `sleep`=1, every input is ignored, the array contents and burst state are kept, and `dout_en` is 0.
- R11: `dout_en` is 0 while `oe_n`=1, and during the period after a captured write cycle.
- R12: After reset no burst is active and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state (not the array) |
| addr | input | ADDR_W | External word address |
| strb_proc_n | input | 1 | Processor address strobe, active low; always starts a read |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ilv_mode | input | 1 | Beat order: 0 linear, 1 interleaved |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| gwr_n | input | 1 | Global write, active low, writes all lanes |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Power-down, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Flow-through read data |
| dout_en | output | 1 | High when the data pins would be driven |

## Verification
The bench builds the block with `ADDR_W`=8, which gives 256 words, while keeping the 4×9 lane layout. With this size the bench can preload every word with a distinct, address-derived value in a few hundred cycles. Because of that, any mistake in beat order, lane masking or address loading shows up as a wrong word rather than an unknown one. It also lets a long random run revisit each address and each burst wrap many times against the bench's own model.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

   typedef enum logic [2:0] {
      CYC_IDLE,
      CYC_LOAD_P,
      CYC_LOAD_C,
      CYC_DESEL,
      CYC_CONT
   } cyc_e;

   // low two address bits for a given beat
   function automatic logic [1:0] beat_low(input logic [1:0] base_lo,
                                           input logic [1:0] beat,
                                           input logic       ilv);
      return ilv ? (base_lo ^ beat) : (base_lo + beat);
   endfunction

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
   import sbs_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             strb_proc_n,
   input  logic             strb_ctl_n,
   input  logic             adv_n,
   input  logic             cs0_n,
   input  logic             cs1,
   input  logic             cs2_n,
   input  logic             gwr_n,
   input  logic             bwr_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic             sleep,
   input  logic             act_q,
   output cyc_e             cyc,
   output logic             step,
   output logic [LANES-1:0] lane_we
);

   logic             sel;
   logic [LANES-1:0] mask;

   assign sel = ~cs0_n & cs1 & ~cs2_n;

   always_comb begin
      if (!gwr_n)      mask = '1;
      else if (!bwr_n) mask = ~lane_sel_n;
      else             mask = '0;
   end

   always_comb begin
      if (sleep)                    cyc = CYC_IDLE;
      else if (!strb_proc_n && sel) cyc = CYC_LOAD_P;
      else if (!strb_ctl_n)         cyc = sel ? CYC_LOAD_C : CYC_DESEL;
      else if (act_q)               cyc = CYC_CONT;
      else                          cyc = CYC_IDLE;
   end

   assign step    = (cyc == CYC_CONT) && !adv_n;
   assign lane_we = ((cyc == CYC_LOAD_C) || (cyc == CYC_CONT)) ? mask : '0;

endmodule

// File: rtl/sbs_burst.sv
module sbs_burst
   import sbs_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_e              cyc,
   input  logic              step,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              mode_in,
   output logic              act_q,
   output logic [ADDR_W-1:0] nxt_addr,
   output logic [ADDR_W-1:0] cur_addr
);

   logic [ADDR_W-1:0] base_q, nbase;
   logic [1:0]        beat_q, nbeat;
   logic              ilv_q, nilv, nact;

   always_comb begin
      nbase = base_q;
      nbeat = beat_q;
      nilv  = ilv_q;
      nact  = act_q;
      unique case (cyc)
         CYC_LOAD_P, CYC_LOAD_C: begin
            nbase = addr_in;
            nbeat = 2'd0;
            nilv  = mode_in;
            nact  = 1'b1;
         end
         CYC_DESEL: nact = 1'b0;
         CYC_CONT:  if (step) nbeat = beat_q + 2'd1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         beat_q <= '0;
         ilv_q  <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         base_q <= nbase;
         beat_q <= nbeat;
         ilv_q  <= nilv;
         act_q  <= nact;
      end
   end

   assign nxt_addr = {nbase[ADDR_W-1:2], beat_low(nbase[1:0], nbeat, nilv)};
   assign cur_addr = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], beat_q, ilv_q)};

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
   parameter int ADDR_W = 16,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DEPTH  = 1 << ADDR_W,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic [LANES-1:0]  we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
   end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
   import sbs_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              strb_proc_n,
   input  logic              strb_ctl_n,
   input  logic              adv_n,
   input  logic              ilv_mode,
   input  logic              cs0_n,
   input  logic              cs1,
   input  logic              cs2_n,
   input  logic              gwr_n,
   input  logic              bwr_n,
   input  logic [LANES-1:0]  lane_sel_n,
   input  logic              oe_n,
   input  logic              sleep,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   if (ADDR_W < 2 || ADDR_W > 20) begin : g_bad_addr
      $error("sync_burst_sram: ADDR_W must lie in 2..20");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("sync_burst_sram: LANES and LANE_W must be positive");
   end

   cyc_e              cyc;
   logic              step;
   logic [LANES-1:0]  lane_we;
   logic              act_q;
   logic              wr_q;
   logic [ADDR_W-1:0] nxt_addr;
   logic [ADDR_W-1:0] cur_addr;

   sbs_ctrl #(.LANES(LANES)) u_ctrl (
      .strb_proc_n(strb_proc_n),
      .strb_ctl_n (strb_ctl_n),
      .adv_n      (adv_n),
      .cs0_n      (cs0_n),
      .cs1        (cs1),
      .cs2_n      (cs2_n),
      .gwr_n      (gwr_n),
      .bwr_n      (bwr_n),
      .lane_sel_n (lane_sel_n),
      .sleep      (sleep),
      .act_q      (act_q),
      .cyc        (cyc),
      .step       (step),
      .lane_we    (lane_we)
   );

   sbs_burst #(.ADDR_W(ADDR_W)) u_burst (
      .clk     (clk),
      .rst_n   (rst_n),
      .cyc     (cyc),
      .step    (step),
      .addr_in (addr),
      .mode_in (ilv_mode),
      .act_q   (act_q),
      .nxt_addr(nxt_addr),
      .cur_addr(cur_addr)
   );

   sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk  (clk),
      .we   (lane_we),
      .waddr(nxt_addr),
      .wdata(din),
      .raddr(cur_addr),
      .rdata(dout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wr_q <= 1'b0;
      else if (!sleep) wr_q <= |lane_we;
   end

   assign dout_en = act_q & ~wr_q & ~oe_n & ~sleep;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              strb_proc_n,
   input logic              strb_ctl_n,
   input logic              adv_n,
   input logic              cs0_n,
   input logic              cs1,
   input logic              cs2_n,
   input logic              oe_n,
   input logic              sleep,
   input logic              dout_en,
   input logic              act_q,
   input logic              wr_q,
   input logic [ADDR_W-1:0] cur_addr
);

   logic selected;
   assign selected = ~cs0_n & cs1 & ~cs2_n;

   a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dout_en);

   a_r10_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> ($stable(cur_addr) && $stable(act_q)));

   a_r11_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dout_en);

   a_r11_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |-> !dout_en);

   a_r8_proc_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !strb_proc_n && selected) |=> (act_q && !wr_q));

   a_r9_desel_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !strb_ctl_n && (strb_proc_n || !selected) && !selected) |=> !act_q);

   a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !strb_ctl_n && strb_proc_n && selected) |=> (act_q && cur_addr == $past(addr)));

   a_r3_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && act_q && (strb_proc_n || !selected) && strb_ctl_n && adv_n)
      |=> $stable(cur_addr));

endmodule

bind sync_burst_sram sbs_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr       (addr),
   .strb_proc_n(strb_proc_n),
   .strb_ctl_n (strb_ctl_n),
   .adv_n      (adv_n),
   .cs0_n      (cs0_n),
   .cs1        (cs1),
   .cs2_n      (cs2_n),
   .oe_n       (oe_n),
   .sleep      (sleep),
   .dout_en    (dout_en),
   .act_q      (act_q),
   .wr_q       (wr_q),
   .cur_addr   (cur_addr)
);

// File: tb/sim_sync_burst_sram.sv
`timescale 1ns/1ps
module sim_sync_burst_sram;

   localparam int AW    = 8;
   localparam int NL    = 4;
   localparam int LW    = 9;
   localparam int DW    = NL * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          strb_proc_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1, ilv_mode = 1'b0;
   logic          cs0_n = 1'b0, cs1 = 1'b1, cs2_n = 1'b0;
   logic          gwr_n = 1'b1, bwr_n = 1'b1;
   logic [NL-1:0] lane_sel_n = '1;
   logic          oe_n = 1'b0, sleep = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sync_burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .strb_proc_n(strb_proc_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
      .ilv_mode(ilv_mode), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
      .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_sel_n(lane_sel_n),
      .oe_n(oe_n), .sleep(sleep), .din(din), .dout(dout), .dout_en(dout_en)
   );

   // reference state
   logic [DW-1:0] m_mem [DEPTH];
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_beat = '0;
   logic          m_ilv = 1'b0, m_act = 1'b0, m_wr = 1'b0;

   function automatic logic [DW-1:0] fillval(input logic [AW-1:0] a);
      return {a, ~a, a, a + 8'd7, 4'h9};
   endfunction

   function automatic logic [AW-1:0] m_addr();
      logic [1:0] lo;
      lo = m_ilv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
      return {m_base[AW-1:2], lo};
   endfunction

   task automatic model_edge();
      logic          sel;
      logic [NL-1:0] mask;
      if (sleep) return;
      sel = !cs0_n && cs1 && !cs2_n;
      mask = !gwr_n ? '1 : (!bwr_n ? ~lane_sel_n : '0);
      if (!strb_proc_n && sel) begin
         m_act = 1; m_base = addr; m_beat = 0; m_ilv = ilv_mode; m_wr = 0;
      end else if (!strb_ctl_n) begin
         if (sel) begin
            m_act = 1; m_base = addr; m_beat = 0; m_ilv = ilv_mode; m_wr = |mask;
         end else begin
            m_act = 0; m_wr = 0;
         end
      end else if (m_act) begin
         if (!adv_n) m_beat = m_beat + 2'd1;
         m_wr = |mask;
      end else begin
         m_wr = 0;
      end
      if (m_wr) begin
         for (int i = 0; i < NL; i++)
            if (mask[i]) m_mem[m_addr()][i*LW +: LW] = din[i*LW +: LW];
      end
   endtask

   task automatic check(input string req, input logic [DW-1:0] act_v, input logic [DW-1:0] exp_v);
      checks++;
      if (act_v !== exp_v) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
      end
   endtask

   task automatic tick(input string req);
      logic exp_en;
      @(posedge clk);
      model_edge();
      #2;
      exp_en = m_act && !m_wr && !oe_n && !sleep;
      check(req, {35'd0, dout_en}, {35'd0, exp_en});
      if (exp_en) check(req, dout, m_mem[m_addr()]);
      @(negedge clk);
   endtask

   task automatic quiet();
      strb_proc_n = 1; strb_ctl_n = 1; adv_n = 1;
      gwr_n = 1; bwr_n = 1; lane_sel_n = '1;
      cs0_n = 0; cs1 = 1; cs2_n = 0; oe_n = 0; sleep = 0;
   endtask

   // four-beat burst from a controller strobe; wr selects global write
   task automatic burst(input logic [AW-1:0] a, input bit ilv, input bit wr, input string req);
      quiet(); addr = a; ilv_mode = ilv; strb_ctl_n = 0; gwr_n = !wr;
      din = {$urandom, 4'($urandom)};
      tick(req);
      for (int k = 0; k < 3; k++) begin
         quiet(); adv_n = 0; gwr_n = !wr; din = {$urandom, 4'($urandom)};
         tick(req);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] keep;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check("R12", {35'd0, dout_en}, 36'd0);
      rst_n = 1;
      @(negedge clk);
      tick("R12");

      // preload every word with a distinct value (R7 global write)
      for (int b = 0; b < DEPTH / 4; b++) begin
         for (int k = 0; k < 4; k++) begin
            quiet(); gwr_n = 0; bwr_n = k[0]; lane_sel_n = 4'(k);
            if (k == 0) begin addr = AW'(b * 4); strb_ctl_n = 0; end
            else adv_n = 0;
            din = fillval(AW'(b * 4 + k));
            tick("R7");
         end
      end
      for (int a = 0; a < DEPTH; a++) m_mem[a] = fillval(AW'(a));

      // linear read from 3: 3,0,1,2 (R4, R1, R2)
      quiet(); addr = 8'h23; ilv_mode = 0; strb_proc_n = 0; tick("R2");
      check("R2", dout, fillval(8'h23));
      quiet(); adv_n = 0; tick("R4"); check("R4", dout, fillval(8'h20));
      quiet(); adv_n = 0; tick("R4"); check("R4", dout, fillval(8'h21));
      quiet(); adv_n = 0; tick("R4"); check("R4", dout, fillval(8'h22));
      quiet(); adv_n = 0; tick("R4"); check("R4", dout, fillval(8'h23));

      // interleaved read from 2: 2,3,0,1 (R5)
      quiet(); addr = 8'h46; ilv_mode = 1; strb_ctl_n = 0; tick("R5");
      check("R5", dout, fillval(8'h46));
      quiet(); adv_n = 0; tick("R5"); check("R5", dout, fillval(8'h47));
      quiet(); adv_n = 0; tick("R5"); check("R5", dout, fillval(8'h44));
      quiet(); adv_n = 0; tick("R5"); check("R5", dout, fillval(8'h45));
      quiet(); ilv_mode = 0; tick("R1"); check("R1", {35'd0, dout_en}, 36'd1);

      // hold without advance (R3)
      quiet(); adv_n = 1; tick("R3"); check("R3", dout, fillval(8'h45));
      quiet(); tick("R3"); check("R3", dout, fillval(8'h45));

      // byte write of lanes 0 and 2 (R6), then read back
      quiet(); addr = 8'h10; strb_ctl_n = 0; bwr_n = 0; lane_sel_n = 4'b1010;
      din = 36'hF_FFFF_FFFF; tick("R6");
      check("R6", {35'd0, dout_en}, 36'd0);
      keep = fillval(8'h10);
      keep[8:0] = 9'h1FF; keep[26:18] = 9'h1FF;
      quiet(); addr = 8'h10; strb_proc_n = 0; tick("R6");
      check("R6", dout, keep);

      // processor strobe with write controls is a read (R8)
      quiet(); addr = 8'h30; strb_proc_n = 0; gwr_n = 0; din = '0; tick("R8");
      check("R8", dout, fillval(8'h30));
      quiet(); addr = 8'h31; strb_proc_n = 0; strb_ctl_n = 0; gwr_n = 0; tick("R8");
      check("R8", dout, fillval(8'h31));

      // deselected strobes (R9)
      quiet(); addr = 8'h50; strb_proc_n = 0; cs1 = 0; tick("R9");
      check("R9", dout, fillval(8'h31));
      quiet(); addr = 8'h50; strb_ctl_n = 0; cs2_n = 1; tick("R9");
      check("R9", {35'd0, dout_en}, 36'd0);
      quiet(); adv_n = 0; gwr_n = 0; din = '0; tick("R9");
      quiet(); addr = 8'h31; strb_proc_n = 0; tick("R9");
      check("R9", dout, fillval(8'h31));

      // sleep (R10)
      quiet(); sleep = 1; addr = 8'h60; strb_ctl_n = 0; gwr_n = 0; din = '0; tick("R10");
      check("R10", {35'd0, dout_en}, 36'd0);
      quiet(); sleep = 1; adv_n = 0; gwr_n = 0; tick("R10");
      quiet(); tick("R10"); check("R10", dout, fillval(8'h31));
      quiet(); addr = 8'h60; strb_proc_n = 0; tick("R10");
      check("R10", dout, fillval(8'h60));

      // output enable gating (R11)
      quiet(); oe_n = 1; tick("R11"); check("R11", {35'd0, dout_en}, 36'd0);
      quiet(); gwr_n = 0; din = 36'h1_2345_6789; tick("R11");
      check("R11", {35'd0, dout_en}, 36'd0);

      // directed bursts both orders
      burst(8'h81, 1'b0, 1'b1, "R4");
      burst(8'h81, 1'b0, 1'b0, "R4");
      burst(8'h93, 1'b1, 1'b1, "R5");
      burst(8'h93, 1'b1, 1'b0, "R5");

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         addr        = AW'($urandom);
         din         = {$urandom, 4'($urandom)};
         strb_proc_n = ($urandom_range(7) != 0);
         strb_ctl_n  = ($urandom_range(5) != 0);
         adv_n       = ($urandom_range(1) != 0);
         ilv_mode    = ($urandom_range(1) != 0);
         cs0_n       = ($urandom_range(11) == 0);
         cs1         = ($urandom_range(11) != 0);
         cs2_n       = ($urandom_range(11) == 0);
         gwr_n       = ($urandom_range(7) != 0);
         bwr_n       = ($urandom_range(3) != 0);
         lane_sel_n  = NL'($urandom);
         oe_n        = ($urandom_range(7) == 0);
         sleep       = ($urandom_range(15) == 0);
         tick("R1");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule